// File: doc/BRIEF.md
# Difference-Bit Two-Way Cache Controller

This block is the lookup and fill controller of a small two-way set-associative cache. Its defining feature is that the way to read is chosen before any tag comparison. Each set remembers a bit position at which its two stored tags disagree, together with a flag that says which way holds a one there. A lookup reads the incoming tag bit at that position and goes straight to one way. Only that way's tag is compared with the request, so a hit is known in the same cycle the request is presented. There is no second, slower class of hit.

A requester holds `req_valid` with its address, direction and write data until `req_done` pulses. On a hit `req_done` rises in the same cycle. A read hit returns its word on `rd_data`. A write hit stores `req_wdata` into the selected way at the clock edge. On a miss the controller stalls the request port. It raises `mem_req` with the word address toward next-level memory and waits for a one-cycle `mem_valid` carrying the line in `mem_rdata`. It then installs the line, recomputes that set's distinguishing bit, and releases the port. The held request then completes as a hit. Writes are allocated and kept in the cache only, and an evicted line is dropped. Each line holds one word, and address bits `[SET_W-1:0]` pick the set.

Top module: `diffbit_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1 and `mem_req` is 0, so the first access to any address misses.
- R2: When the selected way holds the request tag, `req_done` is 1 in the same cycle the request is presented with `req_ready` high. For a read, `rd_data` carries the stored word in that cycle.
- R3: On a miss `req_done` stays 0. From the next cycle `mem_req` is 1, `mem_addr` equals the missing `req_addr` and stays stable, and `req_ready` is 0 for as long as `mem_req` is 1.
- R4: The cycle after `mem_valid` is seen during a refill, `mem_req` is 0 and `req_ready` is 1. The held request then hits, and a read returns the `mem_rdata` word.
- R5: A refill fills an invalid way of the set when one exists (way 0 before way 1), so two different tags in one set both stay resident.
- R6: When both ways are valid, the refill evicts the way that was not the more recently completed access in that set.
- R7: Whenever both ways of a set are valid, the stored position is the lowest bit at which the two tags differ, and the polarity flag equals way 1's tag bit there. Tags that differ only in their top bit, or only in bit 0, must both hit.
- R8: A write hit changes only the selected way's word. The other way of the same set is unchanged.
- R9: A write miss refills the line and then stores `req_wdata`, so a later read returns the written word.
- R10: A `mem_valid` pulse while no refill is pending changes no cache state. `req_ready` stays 1, and resident lines keep their data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present, held until `req_done` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address: set in the low `SET_W` bits, tag above |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Port accepts lookups (0 while refilling) |
| req_done | output | 1 | Request completed as a hit this cycle |
| rd_data | output | DATA_W | Read word of the selected way |
| mem_req | output | 1 | Refill request toward next-level memory |
| mem_addr | output | ADDR_W | Word address being refilled |
| mem_valid | input | 1 | One-cycle refill response |
| mem_rdata | input | DATA_W | Refill word |

## Verification
The hardest case to reach is a set where both ways are valid and their tags differ only at an extreme bit position. That is where a wrong distinguishing-bit position or polarity would send the lookup to the wrong way. The stimulus pairs addresses whose tags differ only in the top bit or only in bit 0. It then replaces one way of a full set, which forces the position to be recomputed against the survivor. A reference model of an ordinary two-way LRU cache predicts the hit or miss and the data for every access. A stray memory response is sent while the controller is idle to show it is ignored.

// File: rtl/dbc_pkg.sv
package dbc_pkg;

    typedef enum logic [0:0] {
        FILL_IDLE = 1'b0,
        FILL_WAIT = 1'b1
    } fill_state_e;

    typedef struct packed {
        logic hit;
        logic way;
    } lookup_t;

    localparam int WAYS = 2;

endpackage

// File: rtl/dbc_way_select.sv
module dbc_way_select
    import dbc_pkg::*;
#(
    parameter int TAG_W = 14,
    parameter int IDX_W = 4
) (
    input  logic [TAG_W-1:0] req_tag,
    input  logic [TAG_W-1:0] tag0,
    input  logic [TAG_W-1:0] tag1,
    input  logic             vld0,
    input  logic             vld1,
    input  logic [IDX_W-1:0] diff_idx,
    input  logic             diff_pol,
    output lookup_t          result
);

    logic pick;
    logic [TAG_W-1:0] cand_tag;
    logic cand_vld;

    always_comb begin
        if (vld0 && vld1) begin
            pick = (req_tag[diff_idx] == diff_pol);
        end else begin
            pick = vld1 && !vld0;
        end
        cand_tag   = pick ? tag1 : tag0;
        cand_vld   = pick ? vld1 : vld0;
        result.way = pick;
        result.hit = cand_vld && (cand_tag == req_tag);
    end

endmodule

// File: rtl/dbc_diff_encoder.sv
module dbc_diff_encoder #(
    parameter int TAG_W = 14,
    parameter int IDX_W = 4
) (
    input  logic [TAG_W-1:0] tag_a,
    input  logic [TAG_W-1:0] tag_b,
    output logic [IDX_W-1:0] low_pos
);

    logic [TAG_W-1:0] differ;
    logic [TAG_W:0]   seen_below;

    assign seen_below[0] = 1'b0;

    for (genvar b = 0; b < TAG_W; b++) begin : g_bit
        assign differ[b]       = tag_a[b] ^ tag_b[b];
        assign seen_below[b+1] = seen_below[b] | differ[b];
    end

    always_comb begin
        low_pos = '0;
        for (int i = 0; i < TAG_W; i++) begin
            if (differ[i] && !seen_below[i]) begin
                low_pos = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/dbc_refill_fsm.sv
module dbc_refill_fsm
    import dbc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              mem_valid,
    output logic              busy,
    output logic [ADDR_W-1:0] line_addr,
    output logic              fill_now
);

    fill_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= FILL_IDLE;
            line_addr <= '0;
        end else begin
            case (state_q)
                FILL_IDLE: begin
                    if (start) begin
                        state_q   <= FILL_WAIT;
                        line_addr <= start_addr;
                    end
                end
                FILL_WAIT: begin
                    if (mem_valid) begin
                        state_q <= FILL_IDLE;
                    end
                end
                default: state_q <= FILL_IDLE;
            endcase
        end
    end

    assign busy     = (state_q == FILL_WAIT);
    assign fill_now = busy && mem_valid;

endmodule

// File: rtl/diffbit_cache.sv
module diffbit_cache
    import dbc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int SET_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              req_done,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int TAG_W = ADDR_W - SET_W;
    localparam int IDX_W = $clog2(TAG_W);
    localparam int SETS  = 1 << SET_W;

    // request side decode
    logic [SET_W-1:0] req_set;
    logic [TAG_W-1:0] req_tag;
    assign req_set = req_addr[SET_W-1:0];
    assign req_tag = req_addr[ADDR_W-1:SET_W];

    // per-set state
    logic [IDX_W-1:0] didx_q [SETS];
    logic [SETS-1:0]  pol_q;
    logic [SETS-1:0]  lru_q;

    // per-way read views
    logic [WAYS-1:0][TAG_W-1:0]  look_tag;
    logic [WAYS-1:0]             look_vld;
    logic [WAYS-1:0][DATA_W-1:0] look_data;
    logic [WAYS-1:0][TAG_W-1:0]  fill_tag_rd;
    logic [WAYS-1:0]             fill_vld;

    // refill side
    logic              busy;
    logic              fill_now;
    logic              miss_start;
    logic [ADDR_W-1:0] line_addr;
    logic [SET_W-1:0]  f_set;
    logic [TAG_W-1:0]  f_tag;
    logic              victim;
    logic [TAG_W-1:0]  surv_tag;
    logic              surv_vld;
    logic [IDX_W-1:0]  new_idx;
    logic              new_pol;

    lookup_t lk;

    // signals observed by the bound checker
    logic             sel_both_valid;
    logic [TAG_W-1:0] sel_tag0;
    logic [TAG_W-1:0] sel_tag1;
    logic [IDX_W-1:0] sel_idx;
    logic             sel_pol;

    assign sel_both_valid = look_vld[0] && look_vld[1];
    assign sel_tag0       = look_tag[0];
    assign sel_tag1       = look_tag[1];
    assign sel_idx        = didx_q[req_set];
    assign sel_pol        = pol_q[req_set];

    dbc_way_select #(
        .TAG_W(TAG_W),
        .IDX_W(IDX_W)
    ) u_sel (
        .req_tag (req_tag),
        .tag0    (look_tag[0]),
        .tag1    (look_tag[1]),
        .vld0    (look_vld[0]),
        .vld1    (look_vld[1]),
        .diff_idx(didx_q[req_set]),
        .diff_pol(pol_q[req_set]),
        .result  (lk)
    );

    assign req_ready  = !busy;
    assign req_done   = req_valid && req_ready && lk.hit;
    assign miss_start = req_valid && req_ready && !lk.hit;
    assign rd_data    = look_data[lk.way];

    dbc_refill_fsm #(
        .ADDR_W(ADDR_W)
    ) u_fill (
        .clk       (clk),
        .rst       (rst),
        .start     (miss_start),
        .start_addr(req_addr),
        .mem_valid (mem_valid),
        .busy      (busy),
        .line_addr (line_addr),
        .fill_now  (fill_now)
    );

    assign mem_req  = busy;
    assign mem_addr = line_addr;
    assign f_set    = line_addr[SET_W-1:0];
    assign f_tag    = line_addr[ADDR_W-1:SET_W];

    // victim: invalid way first, then the LRU way
    always_comb begin
        if (!fill_vld[0]) begin
            victim = 1'b0;
        end else if (!fill_vld[1]) begin
            victim = 1'b1;
        end else begin
            victim = lru_q[f_set];
        end
        surv_tag = fill_tag_rd[!victim];
        surv_vld = fill_vld[!victim];
    end

    dbc_diff_encoder #(
        .TAG_W(TAG_W),
        .IDX_W(IDX_W)
    ) u_enc (
        .tag_a  (f_tag),
        .tag_b  (surv_tag),
        .low_pos(new_idx)
    );

    assign new_pol = victim ? f_tag[new_idx] : surv_tag[new_idx];

    // way storage
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0]  tag_r [SETS];
        logic [DATA_W-1:0] dat_r [SETS];
        logic [SETS-1:0]   vld_r;
        logic              fill_we;
        logic              hit_we;

        assign fill_we = fill_now && (victim == 1'(w));
        assign hit_we  = req_done && req_write && (lk.way == 1'(w));

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_r <= '0;
            end else if (fill_we) begin
                vld_r[f_set] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_we) begin
                tag_r[f_set] <= f_tag;
                dat_r[f_set] <= mem_rdata;
            end else if (hit_we) begin
                dat_r[req_set] <= req_wdata;
            end
        end

        assign look_tag[w]    = tag_r[req_set];
        assign look_vld[w]    = vld_r[req_set];
        assign look_data[w]   = dat_r[req_set];
        assign fill_tag_rd[w] = tag_r[f_set];
        assign fill_vld[w]    = vld_r[f_set];
    end

    // set state: difference position, polarity, recency
    always_ff @(posedge clk) begin
        if (rst) begin
            pol_q <= '0;
            lru_q <= '0;
            for (int s = 0; s < SETS; s++) begin
                didx_q[s] <= '0;
            end
        end else begin
            if (fill_now && surv_vld) begin
                didx_q[f_set] <= new_idx;
                pol_q[f_set]  <= new_pol;
            end
            if (req_done) begin
                lru_q[req_set] <= !lk.way;
            end
        end
    end

endmodule

// File: rtl/dbc_checker.sv
module dbc_checker #(
    parameter int ADDR_W = 16,
    parameter int TAG_W  = 14,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_done,
    input logic [ADDR_W-1:0] req_addr,
    input logic              mem_req,
    input logic              mem_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              sel_both_valid,
    input logic [TAG_W-1:0]  sel_tag0,
    input logic [TAG_W-1:0]  sel_tag1,
    input logic [IDX_W-1:0]  sel_idx,
    input logic              sel_pol
);

    AST_DONE_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        req_done |-> req_ready); // R2

    AST_MISS_OPENS_FILL: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !req_done) |=> (mem_req && mem_addr == $past(req_addr))); // R3

    AST_STALL_IN_FILL: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !req_ready); // R3

    AST_FILL_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr))); // R3

    AST_FILL_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_valid) |=> (req_ready && !mem_req)); // R4

    AST_DIFF_SPLITS_WAYS: assert property (@(posedge clk) disable iff (rst)
        sel_both_valid |-> ((sel_tag0[sel_idx] != sel_tag1[sel_idx]) && (sel_tag1[sel_idx] == sel_pol))); // R7

    AST_IDLE_MEM_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (!mem_req && mem_valid && !(req_valid && req_ready && !req_done)) |=> !mem_req); // R10

endmodule

bind diffbit_cache dbc_checker #(
    .ADDR_W(ADDR_W),
    .TAG_W (TAG_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_done      (req_done),
    .req_addr      (req_addr),
    .mem_req       (mem_req),
    .mem_valid     (mem_valid),
    .mem_addr      (mem_addr),
    .sel_both_valid(sel_both_valid),
    .sel_tag0      (sel_tag0),
    .sel_tag1      (sel_tag1),
    .sel_idx       (sel_idx),
    .sel_pol       (sel_pol)
);

// File: tb/sim_diffbit_cache.sv
`timescale 1ns/1ps
module sim_diffbit_cache;

    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 32;
    localparam int SET_W   = 2;
    localparam int SETS    = 1 << SET_W;
    localparam int MEM_LAT = 3;
    localparam int NVEC    = 20;

    // {write, address, write data}
    localparam logic [48:0] VEC [NVEC] = '{
        {1'b0, 16'h0004, 32'h0},
        {1'b0, 16'h000C, 32'h0},
        {1'b0, 16'h0004, 32'h0},
        {1'b0, 16'h000C, 32'h0},
        {1'b1, 16'h0004, 32'h1111_0001},
        {1'b0, 16'h0004, 32'h0},
        {1'b0, 16'h000C, 32'h0},
        {1'b0, 16'h0014, 32'h0},
        {1'b0, 16'h000C, 32'h0},
        {1'b0, 16'h0004, 32'h0},
        {1'b0, 16'h8001, 32'h0},
        {1'b0, 16'h0001, 32'h0},
        {1'b0, 16'h8001, 32'h0},
        {1'b0, 16'h0001, 32'h0},
        {1'b1, 16'h0006, 32'h2222_0002},
        {1'b0, 16'h0006, 32'h0},
        {1'b0, 16'h0002, 32'h0},
        {1'b0, 16'h0006, 32'h0},
        {1'b0, 16'h0002, 32'h0},
        {1'b0, 16'h0014, 32'h0}
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic              req_write;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata;
    logic              req_ready;
    logic              req_done;
    logic [DATA_W-1:0] rd_data;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_valid;
    logic [DATA_W-1:0] mem_rdata;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  stray    = 1'b0;
    bit  finished = 1'b0;

    // reference: conventional two-way LRU cache
    logic [ADDR_W-1:0] m_tag  [SETS][2];
    logic              m_val  [SETS][2];
    logic [DATA_W-1:0] m_data [SETS][2];
    logic              m_lru  [SETS];

    always #2 clk = ~clk;

    diffbit_cache #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .SET_W (SET_W)
    ) u0 (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .req_ready(req_ready),
        .req_done (req_done),
        .rd_data  (rd_data),
        .mem_req  (mem_req),
        .mem_addr (mem_addr),
        .mem_valid(mem_valid),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [DATA_W-1:0] mem_fn(input logic [ADDR_W-1:0] a);
        return {a ^ 16'hA5C3, a};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < SETS; s++) begin
            m_lru[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin
                m_val[s][w]  = 1'b0;
                m_tag[s][w]  = '0;
                m_data[s][w] = '0;
            end
        end
    endtask

    task automatic model_access(input logic wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                                output bit hit, output logic [DATA_W-1:0] rd);
        int s;
        int way;
        s   = int'(a[SET_W-1:0]);
        hit = 1'b0;
        way = 0;
        for (int w = 0; w < 2; w++) begin
            if (m_val[s][w] && m_tag[s][w] == a) begin
                hit = 1'b1;
                way = w;
            end
        end
        if (!hit) begin
            if (!m_val[s][0]) way = 0;
            else if (!m_val[s][1]) way = 1;
            else way = int'(m_lru[s]);
            m_val[s][way]  = 1'b1;
            m_tag[s][way]  = a;
            m_data[s][way] = mem_fn(a);
        end
        if (wr) m_data[s][way] = wd;
        rd = m_data[s][way];
        m_lru[s] = (way == 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_clear();
        #1;
        check(req_ready === 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        check(mem_req === 1'b0, "R1 no refill after reset", 32'(mem_req), 32'd0);
    endtask

    // exp_hit: -1 = take the model's answer only, 0/1 = also required explicitly
    task automatic do_access(input logic wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                             input string tag, input int exp_hit);
        bit mh;
        logic [DATA_W-1:0] md;
        bit got_hit;
        int cyc;
        model_access(wr, a, wd, mh, md);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = wd;
        #1;
        got_hit = req_done;
        check(got_hit == mh, {tag, " hit/miss vs model"}, 32'(got_hit), 32'(mh));
        if (exp_hit >= 0) begin
            check(got_hit == exp_hit[0], {tag, " hit/miss"}, 32'(got_hit), 32'(exp_hit));
        end
        if (!got_hit) begin
            @(negedge clk);
            #1;
            check(mem_req && !req_ready && mem_addr == a, "R3 refill request",
                  {mem_req, req_ready, 14'd0, mem_addr}, {2'b10, 14'd0, a});
            cyc = 0;
            while (!req_done && cyc < 50) begin
                @(negedge clk);
                #1;
                cyc++;
            end
            check(req_done === 1'b1, "R4 retry completes after fill", 32'(req_done), 32'd1);
        end
        if (!wr) begin
            check(rd_data === md, {tag, " read data"}, rd_data, md);
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        req_write = 1'b0;
    endtask

    // next-level memory responder
    initial begin
        mem_valid = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            mem_valid = 1'b0;
            if (stray) begin
                mem_rdata = 32'hDEAD_BEEF;
                mem_valid = 1'b1;
                stray     = 1'b0;
            end else if (mem_req) begin
                repeat (MEM_LAT) @(negedge clk);
                mem_rdata = mem_fn(mem_addr);
                mem_valid = 1'b1;
            end
        end
    end

    initial begin
        #(4 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

    initial begin
        rst       = 1'b1;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = '0;
        req_wdata = '0;
        model_clear();
        do_reset();

        // table walk: R2 hits, R4 fills, R6 eviction in set 0, R7 top-bit and bit-0 pairs, R8/R9 writes
        for (int i = 0; i < NVEC; i++) begin
            do_access(VEC[i][48], VEC[i][47:32], VEC[i][31:0], "R2/R4/R7/R8/R9 table", -1);
        end

        // R1: reset drops every line
        do_reset();
        do_access(1'b0, 16'h0004, 32'h0, "R1 miss after reset", 0);

        // R5: invalid ways are filled before anything is evicted
        do_access(1'b0, 16'h0003, 32'h0, "R5 first tag", 0);
        do_access(1'b0, 16'h0007, 32'h0, "R5 second tag", 0);
        do_access(1'b0, 16'h0003, 32'h0, "R5 first tag kept", 1);
        do_access(1'b0, 16'h0007, 32'h0, "R5 second tag kept", 1);

        // R6: least recently used way is the victim
        do_access(1'b0, 16'h0003, 32'h0, "R6 touch", 1);
        do_access(1'b0, 16'h000B, 32'h0, "R6 third tag", 0);
        do_access(1'b0, 16'h0003, 32'h0, "R6 recent survives", 1);
        do_access(1'b0, 16'h0007, 32'h0, "R6 old evicted", 0);

        // R8: write hit leaves the other way alone
        do_access(1'b1, 16'h0003, 32'h3333_0003, "R8 write hit", 1);
        do_access(1'b0, 16'h0007, 32'h0, "R8 other way", 1);
        do_access(1'b0, 16'h0003, 32'h0, "R8 written way", 1);

        // R10: stray response while idle
        stray = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(req_ready === 1'b1 && mem_req === 1'b0, "R10 idle after stray",
              {30'd0, req_ready, mem_req}, 32'd2);
        do_access(1'b0, 16'h0003, 32'h0, "R10 resident line unchanged", 1);
        do_access(1'b0, 16'h0013, 32'h0, "R10 no line installed", 0);

        summary();
    end

endmodule